// File: doc/BRIEF.md
# Performance-Monitor Counter and Event Bank

This block keeps a bank of error counters and sticky event flags for a line framer. A byte-wide host register port with a parity bit reads and writes them. Each counter counts single-cycle error pulses. On a performance-monitor strobe, every counter value moves into a read-only holding register and the counter starts again from zero, so software always reads complete intervals.

A control register sets four things at run time:
- how event flags are cleared: write-one-to-clear, or clear-on-read;
- whether counters wrap to zero or hold at full scale;
- where the strobe comes from: an external pin, an internal one-second prescaler, or a self-clearing software bit;
- whether the data/parity bus uses even or odd parity.

The host port is a plain select/write strobe with registered read data. Each access takes one cycle and is always accepted. There is no back-pressure, so no valid/ready handshake applies.

Top module: `pm_stat_bank`

## Requirements
- R1: After reset, the control register (address 0), the event register (address 2) and every holding register (addresses 8+i) read as zero.
- R2: Control bits 7:5 are reserved. They read as zero and writing them changes nothing. Bit 0 selects clear-on-read, bit 1 selects saturation, bits 3:2 select the strobe mode and bit 4 selects odd parity.
- R3: Each cycle with `err_in[i]` high adds one to counter i. On a strobe cycle, holding register i takes the counter value and the counter restarts. An error in that same cycle counts as 1 in the new interval.
- R4: With control bit 1 at 0, a counter at 255 wraps to 0 on the next error.
- R5: With control bit 1 at 1, a counter at 255 stays at 255.
- R6: With strobe mode 00 or 10, each rising edge on `pm_pin` gives exactly one strobe cycle on `pm_tick`, after a two-flop synchronizer. A pin held high gives no further strobes.
- R7: With strobe mode 01, the internal prescaler gives one single-cycle strobe every TICKS_PER_SEC clock cycles.
- R8: With strobe mode 11, writing 1 to bit 0 of address 1 gives one strobe cycle. Address 1 reads as zero. The pin causes no strobe in this mode.
- R9: A cycle with `evt_in[k]` high sets event bit k of address 2. The bit stays set until it is cleared.
- R10: With control bit 0 at 0, writing 1 to an event bit clears it and writing 0 leaves it alone. Reads do not clear event bits.
- R11: With control bit 0 at 1, a read of address 2 returns the event bits and clears the bits it returned. Writes to address 2 have no effect in this mode.
- R12: If an event arrives in the same cycle as its clear, the event bit stays set.
- R13: The total number of ones across `bus_rdata` and `bus_rpar` is even when control bit 4 is 0 and odd when it is 1.
- R14: A write whose `bus_wdata` plus `bus_wpar` fails the selected parity is discarded. It sets sticky event bit 4 (parity error), which is cleared like the other event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wpar | input | 1 | Write parity bit |
| bus_rdata | output | 8 | Read data, valid the cycle after the read |
| bus_rpar | output | 1 | Read parity bit |
| err_in | input | NUM_CNT | Error pulses, one count per high cycle |
| evt_in | input | NUM_EVT | Event pulses |
| pm_pin | input | 1 | External strobe pin, asynchronous |
| pm_tick | output | 1 | Selected strobe, one cycle wide |

## Verification
The bench puts an error on the exact cycle of a software strobe. A design that drops it, or puts it into the closed interval, shows a holding value of 0 where 1 is expected. Event bits are set in the same cycle as a write-one clear and as a clear-on-read access. A design that lets the clear win loses the event.

Counters are driven past 255 in both full-scale modes, which catches wrap and hold being swapped. A pin held high for many cycles, and a pin used outside pin mode, would give extra strobes on a design that does not detect edges or does not gate the source. Bad-parity writes are aimed at the control register, so any partial update shows up on readback.

// File: rtl/pm_stat_pkg.sv
package pm_stat_pkg;
  typedef struct packed {
    logic       odd_par;
    logic [1:0] pm_mode;
    logic       sat;
    logic       cor;
  } pm_ctrl_t;

  localparam logic [1:0] MODE_TIMER = 2'b01;
  localparam logic [1:0] MODE_SOFT  = 2'b11;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_SOFT = 1;
  localparam int unsigned REG_EVT  = 2;
  localparam int unsigned REG_HOLD = 8;
endpackage

// File: rtl/pm_strobe_src.sv
module pm_strobe_src import pm_stat_pkg::*; #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       pin,
  input  logic       soft_pulse,
  output logic       tick
);
  localparam int unsigned PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [2:0]    pin_sh;
  logic [PW-1:0] pre_q;
  logic          pin_rise, timer_hit, timer_mode, soft_mode;

  assign timer_mode = (mode == MODE_TIMER);
  assign soft_mode  = (mode == MODE_SOFT);

  always_ff @(posedge clk) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[1:0], pin};
  end
  assign pin_rise = pin_sh[1] & ~pin_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n || !timer_mode) pre_q <= '0;
    else if (pre_q == LAST)    pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end
  assign timer_hit = timer_mode && (pre_q == LAST);

  always_comb begin
    if (timer_mode)     tick = timer_hit;
    else if (soft_mode) tick = soft_pulse;
    else                tick = pin_rise;
  end

  a_r6_pin_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && !soft_mode && tick) |=> !tick);
  a_r7_timer_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_mode && tick) |=> !tick);
endmodule

// File: rtl/pm_err_counter.sv
module pm_err_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             tick,
  input  logic             sat,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] FULL = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hold  <= '0;
    end else if (tick) begin
      hold  <= cnt_q;
      cnt_q <= CNT_W'(inc);
    end else if (inc && !(sat && cnt_q == FULL)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (hold == $past(cnt_q)) && (cnt_q == CNT_W'($past(inc))));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && inc && !sat && cnt_q == FULL) |=> cnt_q == '0);
  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && sat && cnt_q == FULL) |=> cnt_q == FULL);
endmodule

// File: rtl/pm_evt_latch.sv
module pm_evt_latch #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & ~clr);
  end

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
endmodule

// File: rtl/pm_stat_bank.sv
module pm_stat_bank import pm_stat_pkg::*; #(
  parameter int unsigned NUM_CNT       = 4,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned NUM_EVT       = 4,
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wpar,
  output logic [7:0]         bus_rdata,
  output logic               bus_rpar,
  input  logic [NUM_CNT-1:0] err_in,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               pm_pin,
  output logic               pm_tick
);
  localparam int unsigned EVW = NUM_EVT + 1;
  localparam int unsigned CW  = $bits(pm_ctrl_t);

  pm_ctrl_t         ctrl_q;
  logic             par_bad, wr_ok, rd_en, soft_q;
  logic [EVW-1:0]   evt_q, evt_set, evt_clr;
  logic [7:0]       rd_mux;
  logic [CNT_W-1:0] hold [NUM_CNT];

  assign par_bad = ((^bus_wdata) ^ bus_wpar) != ctrl_q.odd_par;
  assign wr_ok   = bus_cs && bus_we && !par_bad;
  assign rd_en   = bus_cs && !bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      soft_q <= 1'b0;
    end else begin
      if (wr_ok && bus_addr == ADDR_W'(REG_CTRL))
        ctrl_q <= pm_ctrl_t'(bus_wdata[CW-1:0]);
      soft_q <= wr_ok && bus_addr == ADDR_W'(REG_SOFT) && bus_wdata[0];
    end
  end

  pm_strobe_src #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_src (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.pm_mode), .pin(pm_pin),
    .soft_pulse(soft_q), .tick(pm_tick)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pm_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(err_in[i]), .tick(pm_tick),
      .sat(ctrl_q.sat), .hold(hold[i])
    );
  end

  assign evt_set = {bus_cs && bus_we && par_bad, evt_in};

  always_comb begin
    evt_clr = '0;
    if (bus_cs && bus_addr == ADDR_W'(REG_EVT)) begin
      if (ctrl_q.cor && !bus_we)        evt_clr = evt_q;
      else if (!ctrl_q.cor && wr_ok)    evt_clr = bus_wdata[EVW-1:0];
    end
  end

  pm_evt_latch #(.W(EVW)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .clr(evt_clr), .q(evt_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(REG_CTRL)) rd_mux = 8'(ctrl_q);
    if (bus_addr == ADDR_W'(REG_EVT))  rd_mux = 8'(evt_q);
    for (int i = 0; i < NUM_CNT; i++)
      if (bus_addr == ADDR_W'(REG_HOLD + i)) rd_mux = 8'(hold[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
  assign bus_rpar = (^bus_rdata) ^ ctrl_q.odd_par;

  a_r14_bad_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && par_bad) |=> $stable(ctrl_q) && evt_q[NUM_EVT]);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'(REG_CTRL)) |=> bus_rdata[7:CW] == '0);
  a_r9_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((evt_q[NUM_EVT-1:0] & $past(evt_in)) == $past(evt_in)));
endmodule

// File: tb/pm_stat_bank_test.sv
module pm_stat_bank_test;
  logic       clk = 0, rst_n = 0;
  logic       bus_cs = 0, bus_we = 0, bus_wpar = 0, pm_pin = 0;
  logic [3:0] bus_addr = 0, err_in = 0, evt_in = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       bus_rpar, pm_tick;
  int total = 0, bad = 0, ticks = 0;
  logic cur_odd = 0;

  always #10 clk = ~clk;

  pm_stat_bank #(.TICKS_PER_SEC(20)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wpar(bus_wpar),
    .bus_rdata(bus_rdata), .bus_rpar(bus_rpar), .err_in(err_in),
    .evt_in(evt_in), .pm_pin(pm_pin), .pm_tick(pm_tick)
  );

  always @(negedge clk) if (pm_tick) ticks++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic corrupt = 0);
    bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    bus_wpar = (^d) ^ cur_odd ^ corrupt;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_cs = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_cs = 0;
    d = bus_rdata;
    total++;
    if (((^bus_rdata) ^ bus_rpar) != cur_odd) begin
      bad++;
      $display("FAIL R13 actual=%0b expected=%0b", bus_rpar, (^bus_rdata) ^ cur_odd);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_strobe(input logic [3:0] err_same);
    wr(4'd1, 8'h01);
    err_in = err_same;
    cyc(1);
    err_in = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 4'd0, 0);
    rd_chk("R1 evt", 4'd2, 0);
    rd_chk("R1 hold0", 4'd8, 0);
    rd_chk("R1 hold3", 4'd11, 0);
  endtask

  task automatic t_reserved();
    wr(4'd0, 8'hE0);
    rd_chk("R2 reserved", 4'd0, 0);
  endtask

  task automatic t_parity();
    wr(4'd0, 8'h10);
    cur_odd = 1;
    rd_chk("R13 odd ctrl", 4'd0, 8'h10);
    chk("R13 odd rpar", bus_rpar, 0);
    wr(4'd0, 8'h0C, 1);
    rd_chk("R14 ctrl kept", 4'd0, 8'h10);
    rd_chk("R14 perr bit", 4'd2, 8'h10);
    wr(4'd0, 8'h00);
    cur_odd = 0;
    wr(4'd2, 8'h10);
    rd_chk("R10 perr cleared", 4'd2, 0);
  endtask

  task automatic t_soft();
    wr(4'd0, 8'h0C);
    ticks = 0;
    err_in = 4'b0011; cyc(1);
    err_in = 4'b0001; cyc(2);
    err_in = 0;
    soft_strobe(4'b0001);
    rd_chk("R3 hold0", 4'd8, 3);
    rd_chk("R3 hold1", 4'd9, 1);
    rd_chk("R3 hold2", 4'd10, 0);
    rd_chk("R8 soft reads 0", 4'd1, 0);
    soft_strobe(4'b0000);
    rd_chk("R3 same-cycle error", 4'd8, 1);
    chk("R8 tick count", ticks, 2);
    pm_pin = 1; cyc(6); pm_pin = 0; cyc(6);
    chk("R8 pin ignored", ticks, 2);
  endtask

  task automatic t_rollover();
    wr(4'd0, 8'h0C);
    err_in = 4'b0100; cyc(257); err_in = 0;
    soft_strobe(0);
    rd_chk("R4 wrap", 4'd10, 1);
  endtask

  task automatic t_saturate();
    wr(4'd0, 8'h0E);
    err_in = 4'b1000; cyc(300); err_in = 0;
    soft_strobe(0);
    rd_chk("R5 hold max", 4'd11, 255);
  endtask

  task automatic t_pin();
    wr(4'd0, 8'h00);
    cyc(4);
    ticks = 0;
    err_in = 4'b0001; cyc(4); err_in = 0;
    pm_pin = 1; cyc(10); pm_pin = 0; cyc(10);
    chk("R6 one tick per edge", ticks, 1);
    rd_chk("R6 hold0", 4'd8, 4);
    pm_pin = 1; cyc(10); pm_pin = 0; cyc(10);
    chk("R6 second edge", ticks, 2);
    wr(4'd0, 8'h08);
    pm_pin = 1; cyc(10); pm_pin = 0; cyc(10);
    chk("R6 mode 10", ticks, 3);
  endtask

  task automatic t_timer();
    wr(4'd0, 8'h04);
    ticks = 0;
    cyc(110);
    chk("R7 timer ticks", ticks, 5);
    wr(4'd0, 8'h0C);
    ticks = 0;
    cyc(60);
    chk("R7 timer off", ticks, 0);
  endtask

  task automatic t_w1c();
    wr(4'd0, 8'h00);
    evt_in = 4'b0101; cyc(1); evt_in = 0;
    rd_chk("R9 latched", 4'd2, 8'h05);
    rd_chk("R10 read no clear", 4'd2, 8'h05);
    wr(4'd2, 8'h01);
    rd_chk("R10 w1c", 4'd2, 8'h04);
    evt_in = 4'b0100;
    wr(4'd2, 8'h04);
    evt_in = 0;
    rd_chk("R12 set beats w1c", 4'd2, 8'h04);
  endtask

  task automatic t_cor();
    logic [7:0] d;
    wr(4'd0, 8'h01);
    evt_in = 4'b0010; cyc(1); evt_in = 0;
    rd_chk("R11 cor read", 4'd2, 8'h06);
    rd_chk("R11 cleared", 4'd2, 0);
    evt_in = 4'b1000; cyc(1); evt_in = 0;
    wr(4'd2, 8'h08);
    rd_chk("R11 write ignored", 4'd2, 8'h08);
    evt_in = 4'b0001;
    rd(4'd2, d);
    evt_in = 0;
    rd_chk("R12 set beats cor", 4'd2, 8'h01);
    rd_chk("R11 cleared again", 4'd2, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_reserved();
    t_parity();
    t_soft();
    t_rollover();
    t_saturate();
    t_pin();
    t_timer();
    t_w1c();
    t_cor();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule